// File: doc/BRIEF.md
# SMBus Target Receive Front End with Per-Byte Accept

This block is the receive side of a two-wire management bus target. It takes the raw clock and data lines and passes each through a synchronizer and a glitch filter. It then finds START, repeated START and STOP conditions and shifts in bytes MSB first on the rising clock edges. It acknowledges by asserting an open-drain pull-down enable.

The target acknowledges its own 7-bit address every time it is addressed, whatever its internal condition, so a host can always probe for its presence. Every byte after the address is offered to the user side through a one-cycle strobe that carries the byte and its position in the transfer. In that same cycle the user logic answers on a combinational accept input. A refusal becomes a NACK on that byte, and the final byte of a transfer is no exception. A NACK is the only way the target can tell the host that it is busy or that a command or data value is invalid.

Top module: `smb_target_ack`

## Requirements
- R1: While reset is high and in the cycle after it, `sda_oe` and `byte_vld` are 0.
- R2: A falling data line while the clock is high (START) begins reception of an address byte. A rising data line while the clock is high (STOP) returns the block to idle, with `sda_oe` low from the next cycle.
- R3: An address byte whose upper seven bits equal `own_addr` and whose bit 0 (direction) is 0 is always ACKed, even when `accept_i` is 0. The address byte is never presented on `byte_vld`.
- R4: A matching address with direction bit 1 is ACKed. The rest of that transfer is then ignored: no strobes and no ACK.
- R5: A non-matching address is not ACKed. No strobe and no ACK follow until the next START.
- R6: Each byte after a write address raises `byte_vld` for exactly one cycle, at the eighth rising clock edge of that byte. `byte_data` holds the byte (first bit received in bit 7), and `byte_idx` is 0 for the first byte after the address and increments by one per byte.
- R7: `accept_i` is sampled in the `byte_vld` cycle. A value of 1 produces ACK and 0 produces NACK for that byte, and this holds for every byte, including the last one before STOP.
- R8: `sda_oe` rises only while the filtered clock is low, after the eighth falling edge of a byte. It is released after the ninth falling edge.
- R9: A repeated START in the middle of a transfer restarts address reception and resets `byte_idx` to 0.
- R10: A pulse on either line shorter than `FILT_LEN` clock cycles has no effect on the bits received or on the conditions detected.
- R11: After a NACKed byte the transfer continues, and later bytes are still strobed and answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous, wired-AND with own drive |
| own_addr | input | 7 | Target 7-bit address |
| accept_i | input | 1 | Combinational accept for the strobed byte |
| sda_oe | output | 1 | Data line pull-down enable (1 = drive low) |
| byte_vld | output | 1 | One-cycle strobe for a received data byte |
| byte_data | output | 8 | Received byte, valid with `byte_vld` |
| byte_idx | output | IDX_W | Position of the byte after the address |

## Verification
Two events coincide in one cycle: the byte-valid strobe and the user's accept decision. In that single cycle the block samples `accept_i`, which depends only on the byte being shown. The bench drives `accept_i` combinationally from `byte_data`, refusing any byte whose upper nibble is 0xE. It then reads the ACK/NACK level on the modelled open-drain bus during the ninth clock high phase. A decision sampled one cycle early or late would show up as a wrong acknowledge on a byte whose neighbours get the opposite answer. The last byte before STOP is one such refused byte.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_HOLD,
        ST_ACK,
        ST_SKIP
    } smbt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } smbt_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] own);
        return b[BYTE_W-1:1] == own;
    endfunction

endpackage

// File: rtl/smbt_line_filter.sv
module smbt_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   level_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    // A new level is adopted only after FILT_LEN consecutive differing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_q <= 1'b1;
        end else if (sync_q[SYNC_STAGES-1] == level_q) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            run_q   <= '0;
            level_q <= sync_q[SYNC_STAGES-1];
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign dout = level_q;
endmodule

// File: rtl/smbt_bus_events.sv
module smbt_bus_events
    import smbt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_f,
    input  logic      sda_f,
    output smbt_evt_t evt
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    always_comb begin
        evt.scl_rise = scl_f & ~scl_d;
        evt.scl_fall = ~scl_f & scl_d;
        evt.start    = scl_f & scl_d & sda_d & ~sda_f;
        evt.stop     = scl_f & scl_d & ~sda_d & sda_f;
    end
endmodule

// File: rtl/smb_target_ack.sv
module smb_target_ack
    import smbt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int IDX_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [6:0]        own_addr,
    input  logic              accept_i,
    output logic              sda_oe,
    output logic              byte_vld,
    output logic [7:0]        byte_data,
    output logic [IDX_W-1:0]  byte_idx
);
    localparam int BCW = $clog2(BYTE_W);

    logic [1:0] raw_in;
    logic [1:0] filt;
    logic       scl_f, sda_f;

    assign raw_in = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        smbt_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_in[g]),
            .dout(filt[g])
        );
    end

    assign scl_f = filt[1];
    assign sda_f = filt[0];

    smbt_evt_t evt;

    smbt_bus_events u_evt (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .evt  (evt)
    );

    smbt_state_e           state_q;
    logic [BYTE_W-1:0]     shift_q;
    logic [BCW-1:0]        bit_q;
    logic                  is_addr_q;
    logic                  ack_q;
    logic                  rd_q;
    logic                  oe_q;
    logic [IDX_W-1:0]      idx_q;

    logic [BYTE_W-1:0]     next_byte;
    logic                  byte_done;

    assign next_byte = {shift_q[BYTE_W-2:0], sda_f};
    assign byte_done = (state_q == ST_RECV) && evt.scl_rise &&
                       (bit_q == BCW'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            shift_q   <= '0;
            bit_q     <= '0;
            is_addr_q <= 1'b0;
            ack_q     <= 1'b0;
            rd_q      <= 1'b0;
            oe_q      <= 1'b0;
            idx_q     <= '0;
        end else if (evt.start) begin
            state_q   <= ST_RECV;
            bit_q     <= '0;
            is_addr_q <= 1'b1;
            oe_q      <= 1'b0;
            idx_q     <= '0;
        end else if (evt.stop) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RECV: begin
                    if (evt.scl_rise) begin
                        shift_q <= next_byte;
                        bit_q   <= bit_q + 1'b1;
                        if (byte_done) begin
                            bit_q <= '0;
                            if (is_addr_q) begin
                                if (addr_hit(next_byte, own_addr)) begin
                                    ack_q   <= 1'b1;
                                    rd_q    <= next_byte[0];
                                    state_q <= ST_HOLD;
                                end else begin
                                    state_q <= ST_SKIP;
                                end
                            end else begin
                                ack_q   <= accept_i;
                                state_q <= ST_HOLD;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (evt.scl_fall) begin
                        oe_q    <= ack_q;
                        state_q <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (evt.scl_fall) begin
                        oe_q <= 1'b0;
                        if (is_addr_q) begin
                            is_addr_q <= 1'b0;
                            state_q   <= rd_q ? ST_SKIP : ST_RECV;
                        end else begin
                            if (idx_q != '1) idx_q <= idx_q + 1'b1;
                            state_q <= ST_RECV;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe    = oe_q;
    assign byte_vld  = byte_done && !is_addr_q;
    assign byte_data = next_byte;
    assign byte_idx  = idx_q;

endmodule

// File: rtl/smbt_checker.sv
module smbt_checker (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic byte_vld,
    input logic scl_f,
    input logic start_p,
    input logic stop_p
);
    // R1: quiet outputs after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sda_oe && !byte_vld));

    // R2: STOP releases the data line
    p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !sda_oe);

    // R9: a (repeated) START releases the data line
    p_start_release_r9: assert property (@(posedge clk) disable iff (rst)
        start_p |=> !sda_oe);

    // R6: strobe lasts one cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R8: drive begins only in a clock low phase
    p_drive_in_low_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

    // R6: strobe only while the filtered clock is high
    p_strobe_clk_high_r6: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> scl_f);
endmodule

bind smb_target_ack smbt_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .sda_oe  (sda_oe),
    .byte_vld(byte_vld),
    .scl_f   (scl_f),
    .start_p (evt.start),
    .stop_p  (evt.stop)
);

// File: tb/test_smb_target_ack.sv
module test_smb_target_ack;
    localparam int Q       = 25;
    localparam int IDX_W   = 4;
    localparam int WD_MAX  = 150000;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic force_nack = 1'b0;
    logic sda_bus;
    logic accept_i;
    logic sda_oe, byte_vld;
    logic [7:0] byte_data;
    logic [IDX_W-1:0] byte_idx;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    assign sda_bus  = sda_m & ~sda_oe;
    assign accept_i = !force_nack && (byte_data[7:4] != 4'hE);

    smb_target_ack #(.IDX_W(IDX_W)) i_smb_target_ack (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .own_addr (OWN),
        .accept_i (accept_i),
        .sda_oe   (sda_oe),
        .byte_vld (byte_vld),
        .byte_data(byte_data),
        .byte_idx (byte_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // monitor / scoreboard (R6)
    always @(negedge clk) begin
        if (!rst && byte_vld) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R6 unexpected strobe act=%0h exp=none", byte_data);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk("R6 strobe data/idx", {8'(byte_idx), byte_data}, e);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_MAX && !done) begin
            failures++;
            $display("FAIL watchdog act=%0d exp<%0d", cycles, WD_MAX);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    // sends a byte; glitch injects short pulses on both lines
    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            if (glitch && i == 4) begin
                scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(2);
            end
            scl_m = 1'b1; wq(Q);
            if (glitch && i == 3) begin
                sda_m = ~b[i]; wq(2); sda_m = b[i];
            end
            if (i == 0) chk("R8 no drive before 8th fall", sda_oe, 1'b0);
            wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = !sda_bus;
        wq(Q);
        scl_m = 1'b0; wq(Q);
        chk("R8 released after 9th fall", sda_oe, 1'b0);
    endtask

    task automatic data_byte(input logic [7:0] b, input int idx, input bit glitch);
        bit a;
        exp_q.push_back({8'(idx), b});
        send_byte(b, glitch, a);
        chk("R7 ack follows accept", a, b[7:4] != 4'hE);
    endtask

    initial begin
        bit a;
        wq(5);
        chk("R1 oe in reset", sda_oe, 1'b0);
        chk("R1 vld in reset", byte_vld, 1'b0);
        rst = 1'b0;
        wq(2);
        chk("R1 oe after reset", sda_oe, 1'b0);

        // write transfer, address ACKed even with accept forced low
        bus_start();
        force_nack = 1'b1;
        send_byte({OWN, 1'b0}, 1'b0, a);
        chk("R3 own address acked while busy", a, 1'b1);
        force_nack = 1'b0;
        data_byte(8'h10, 0, 1'b0);
        data_byte(8'hE5, 1, 1'b0);
        data_byte(8'h22, 2, 1'b0);   // R11 continues after NACK
        data_byte(8'hE0, 3, 1'b0);   // R7 final byte NACK
        bus_stop();
        wq(2);
        chk("R2 idle after stop", sda_oe, 1'b0);

        // mismatch
        bus_start();
        send_byte({7'h21, 1'b0}, 1'b0, a);
        chk("R5 foreign address not acked", a, 1'b0);
        send_byte(8'h33, 1'b0, a);
        chk("R5 later byte ignored", a, 1'b0);
        bus_stop();

        // read direction
        bus_start();
        send_byte({OWN, 1'b1}, 1'b0, a);
        chk("R4 read address acked", a, 1'b1);
        send_byte(8'h44, 1'b0, a);
        chk("R4 rest ignored", a, 1'b0);
        bus_stop();

        // repeated START
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, a);
        chk("R2 start begins address", a, 1'b1);
        data_byte(8'h55, 0, 1'b0);
        data_byte(8'h66, 1, 1'b0);
        bus_rstart();
        send_byte({OWN, 1'b0}, 1'b0, a);
        chk("R9 address after restart", a, 1'b1);
        data_byte(8'h77, 0, 1'b0);   // R9 index back to 0
        bus_stop();

        // glitches
        bus_start();
        send_byte({OWN, 1'b0}, 1'b0, a);
        chk("R10 address before glitch", a, 1'b1);
        data_byte(8'h5A, 0, 1'b1);   // R10 glitches filtered
        data_byte(8'hEC, 1, 1'b0);
        bus_stop();

        wq(20);
        chk("R6 all strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule